// File: doc/BRIEF.md
# Low-Power Mode Regulator Sequencer

This block is the digital controller that sits beside the core-supply regulator of a microcontroller. It accepts a requested power-saving mode from the processor (run, sleep, deep-sleep1 or deep-sleep2), together with a one-cycle enter strobe. It then drives the regulator controls: the regulator is switched off, or put in its low-current setting. In deep-sleep2 a weak depletion-MOS retention source is enabled instead, so that retained state keeps power while the main regulator is off.

On the return path the block watches several inputs: wakeup sources, the active-low external reset pin, and three digitised supply comparators (above the power-on level, at or below the brown-out level, below the low-voltage level). All of these are asynchronous and are synchronised inside the block. The regulator comes back only while the supply is above the power-on level. The retention source is released only after a short overlap with the regulator. The block also produces a stretched power reset and two sticky interrupt flags, one for brown-out and one for low-voltage, each with its own enable. A select bit turns a brown-out into either a reset or an interrupt.

All control and status pins are plain levels or single-cycle pulses. The block has no streaming data path, so it uses no valid/ready handshake.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `pwr_state` is 0 (run), `ldo_off`, `ldo_lcm`, `dmos_on`, `bod_irq` and `lvd_irq` are 0, and `sys_rst` is 1.
- R2: A `mode_enter` pulse while `pwr_state` is 0 moves `pwr_state` on the next clock edge to the value of `mode_req` (1 sleep, 2 deep-sleep1, 3 deep-sleep2). A `mode_enter` pulse with `mode_req` = 0, or in any state other than run, leaves `pwr_state` unchanged.
- R3: In deep-sleep1 (state 2) `ldo_lcm` = 1 and `ldo_off` = 0. In run (0) and sleep (1) both are 0.
- R4: In deep-sleep2 (state 3) `ldo_off` = 1 and `dmos_on` = 1. `ldo_off` is never 1 while `dmos_on` is 0.
- R5: Deep-sleep2 is left, for state 4 (settle), only when the synchronised above-power-on flag is 1 and a trigger is present. A trigger is any `wake_src` bit, an active `lvd_wake`, a falling edge of `ext_rst_n`, or `bod_en` = 1 with the supply above the brown-out level.
- R6: Sleep and deep-sleep1 return to run on any `wake_src` bit, an active `lvd_wake`, or a falling edge of `ext_rst_n`.
- R7: In settle, `ldo_off` = 0 and `dmos_on` = 1 for exactly 4 cycles, after which the state is run with `dmos_on` = 0.
- R8: Every asynchronous input (`wake_src`, `ext_rst_n`, the three comparator flags) passes through two flops. A change driven between edges affects combinational outputs after the second following edge and the state after the third.
- R9: `sys_rst` is 1 while the synchronised supply is not above the power-on level, or while `bod_en` = 1, `bod_irq_sel` = 0 and the supply is at or below the brown-out level. It stays 1 for 16 cycles after the cause clears.
- R10: With `bod_irq_sel` = 1, a brown-out never asserts `sys_rst`. It sets a sticky brown-out flag one edge after the condition is synchronised, and `bod_irq` = flag AND `bod_ie`.
- R11: A synchronised below-low-voltage flag sets a sticky flag, and `lvd_irq` = flag AND `lvd_ie`. `lvd_wake` = `lvd_wake_en` AND the synchronised below-low-voltage flag.
- R12: A one-cycle `bod_flag_clr` or `lvd_flag_clr` pulse clears its flag on the next edge. If the set condition holds in the same cycle, the set wins and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested mode: 0 run, 1 sleep, 2 deep-sleep1, 3 deep-sleep2 |
| mode_enter | input | 1 | One-cycle strobe to enter `mode_req` |
| wake_src | input | NWAKE | Asynchronous wakeup sources (timer, external line, wake pin) |
| ext_rst_n | input | 1 | Asynchronous external reset pin, active low |
| vdd_above_por | input | 1 | Comparator: supply above the power-on level |
| vdd_at_bod | input | 1 | Comparator: supply at or below the brown-out level |
| vdd_below_lvd | input | 1 | Comparator: supply below the low-voltage level |
| bod_en | input | 1 | Brown-out detection enable |
| bod_irq_sel | input | 1 | Brown-out action: 0 reset, 1 interrupt |
| bod_ie | input | 1 | Brown-out interrupt enable |
| lvd_ie | input | 1 | Low-voltage interrupt enable |
| lvd_wake_en | input | 1 | Low-voltage wakeup enable |
| bod_flag_clr | input | 1 | Clear pulse for the brown-out flag |
| lvd_flag_clr | input | 1 | Clear pulse for the low-voltage flag |
| ldo_off | output | 1 | Main regulator off |
| ldo_lcm | output | 1 | Main regulator low-current setting |
| dmos_on | output | 1 | Retention source enable |
| sys_rst | output | 1 | Stretched power reset, active high |
| bod_irq | output | 1 | Brown-out interrupt |
| lvd_irq | output | 1 | Low-voltage interrupt |
| lvd_wake | output | 1 | Low-voltage wakeup event |
| pwr_state | output | 3 | Current state: 0 run, 1 sleep, 2 deep-sleep1, 3 deep-sleep2, 4 settle |

## Verification
The brown-out flag can receive a clear pulse in the same cycle as a fresh set condition. The bench provokes this by holding the brown-out comparator low-side while pulsing the clear, and judges it by `bod_irq` staying 1 on the next edge. It then repeats the clear with the condition gone and expects 0. A second overlap is between a held wake source and a low power-on flag in deep-sleep2. The wake must be ignored until the power-on flag returns, and the settle count must start from that edge.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_DS1    = 3'd2,
    ST_DS2    = 3'd3,
    ST_SETTLE = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pwrseq_rst_stretch.sv
module pwrseq_rst_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cause,
  output logic rst_out
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= HOLD_V;
    else if (cause)       cnt <= HOLD_V;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end
  assign rst_out = cause | (cnt != '0);
endmodule

// File: rtl/pwrseq_mode_fsm.sv
module pwrseq_mode_fsm
  import pwrseq_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       mode_enter,
  input  logic       wake_any,
  input  logic       bod_wake,
  input  logic       por_ok,
  output pwr_state_e state,
  output logic       ldo_off,
  output logic       ldo_lcm,
  output logic       dmos_on
);
  localparam int SW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] LAST = SW'(SETTLE - 1);
  logic [SW-1:0] scnt;
  pwr_state_e    nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:
        if (mode_enter && mode_req != 2'd0) nxt = pwr_state_e'({1'b0, mode_req});
      ST_SLEEP, ST_DS1:
        if (wake_any) nxt = ST_RUN;
      ST_DS2:
        if (por_ok && (wake_any || bod_wake)) nxt = ST_SETTLE;
      ST_SETTLE:
        if (scnt == LAST) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      scnt  <= '0;
    end else begin
      state <= nxt;
      if (state == ST_SETTLE && nxt == ST_SETTLE) scnt <= scnt + 1'b1;
      else                                        scnt <= '0;
    end
  end

  assign ldo_off = (state == ST_DS2);
  assign ldo_lcm = (state == ST_DS1);
  assign dmos_on = (state == ST_DS2) || (state == ST_SETTLE);
endmodule

// File: rtl/pwrseq_irq_flags.sv
module pwrseq_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ie,
  output logic [N-1:0] irq
);
  logic [N-1:0] flag;
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
    assign irq[i] = flag[i] & ie[i];
  end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int NWAKE    = 3,
  parameter int SETTLE   = 4,
  parameter int RST_HOLD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_req,
  input  logic             mode_enter,
  input  logic [NWAKE-1:0] wake_src,
  input  logic             ext_rst_n,
  input  logic             vdd_above_por,
  input  logic             vdd_at_bod,
  input  logic             vdd_below_lvd,
  input  logic             bod_en,
  input  logic             bod_irq_sel,
  input  logic             bod_ie,
  input  logic             lvd_ie,
  input  logic             lvd_wake_en,
  input  logic             bod_flag_clr,
  input  logic             lvd_flag_clr,
  output logic             ldo_off,
  output logic             ldo_lcm,
  output logic             dmos_on,
  output logic             sys_rst,
  output logic             bod_irq,
  output logic             lvd_irq,
  output logic             lvd_wake,
  output logic [2:0]       pwr_state
);
  localparam int SW = NWAKE + 4;
  localparam logic [SW-1:0] SYNC_RST = SW'(4'b1000);

  logic [SW-1:0] async_in, sync_out;
  logic [NWAKE-1:0] wake_s;
  logic nrst_s, nrst_d, por_s, bod_s, lvd_s, nrst_fall, wake_any, bod_wake;
  pwr_state_e st;
  logic [1:0] irq_v;

  assign async_in = {wake_src, ext_rst_n, vdd_above_por, vdd_at_bod, vdd_below_lvd};

  pwrseq_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out)
  );
  assign {wake_s, nrst_s, por_s, bod_s, lvd_s} = sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nrst_d <= 1'b1;
    else        nrst_d <= nrst_s;
  end
  assign nrst_fall = nrst_d & ~nrst_s;
  assign lvd_wake  = lvd_wake_en & lvd_s;
  assign wake_any  = (|wake_s) | lvd_wake | nrst_fall;
  assign bod_wake  = bod_en & ~bod_s;

  pwrseq_mode_fsm #(.SETTLE(SETTLE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_enter(mode_enter),
    .wake_any(wake_any), .bod_wake(bod_wake), .por_ok(por_s), .state(st),
    .ldo_off(ldo_off), .ldo_lcm(ldo_lcm), .dmos_on(dmos_on)
  );
  assign pwr_state = st;

  pwrseq_rst_stretch #(.HOLD(RST_HOLD)) u_rst (
    .clk(clk), .rst_n(rst_n),
    .cause(~por_s | (bod_en & ~bod_irq_sel & bod_s)),
    .rst_out(sys_rst)
  );

  pwrseq_irq_flags #(.N(2)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set({lvd_s, bod_en & bod_irq_sel & bod_s}),
    .clr({lvd_flag_clr, bod_flag_clr}),
    .ie({lvd_ie, bod_ie}),
    .irq(irq_v)
  );
  assign {lvd_irq, bod_irq} = irq_v;
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk #(
  parameter int RST_HOLD = 16
) (
  input logic clk,
  input logic rst_n,
  input logic ldo_off,
  input logic ldo_lcm,
  input logic dmos_on,
  input logic sys_rst,
  input logic bod_irq,
  input logic bod_ie,
  input logic bod_flag_clr,
  input logic por_s
);
  logic [5:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_cnt <= '0;
    else if (!sys_rst)         hi_cnt <= '0;
    else if (hi_cnt != 6'h3f)  hi_cnt <= hi_cnt + 1'b1;
  end

  p_lcm_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ldo_lcm |-> !ldo_off);
  p_never_unpowered_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ldo_off |-> dmos_on);
  p_por_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ldo_off) |-> $past(por_s));
  p_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dmos_on) |-> (!ldo_off && $past(!ldo_off)));
  p_rst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (hi_cnt >= 6'(RST_HOLD)));
  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bod_irq) |-> $past(bod_flag_clr || !bod_ie) || !bod_ie);
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .ldo_off(ldo_off), .ldo_lcm(ldo_lcm),
  .dmos_on(dmos_on), .sys_rst(sys_rst), .bod_irq(bod_irq), .bod_ie(bod_ie),
  .bod_flag_clr(bod_flag_clr), .por_s(por_s)
);

// File: tb/sim_pwrseq_ctrl.sv
`timescale 1ns/1ps
module sim_pwrseq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_req = 2'd0;
  logic mode_enter = 1'b0;
  logic [2:0] wake_src = 3'd0;
  logic ext_rst_n = 1'b1, vdd_above_por = 1'b1, vdd_at_bod = 1'b0, vdd_below_lvd = 1'b0;
  logic bod_en = 1'b0, bod_irq_sel = 1'b0, bod_ie = 1'b0, lvd_ie = 1'b0, lvd_wake_en = 1'b0;
  logic bod_flag_clr = 1'b0, lvd_flag_clr = 1'b0;
  logic ldo_off, ldo_lcm, dmos_on, sys_rst, bod_irq, lvd_irq, lvd_wake;
  logic [2:0] pwr_state;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pwrseq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_enter(mode_enter),
    .wake_src(wake_src), .ext_rst_n(ext_rst_n), .vdd_above_por(vdd_above_por),
    .vdd_at_bod(vdd_at_bod), .vdd_below_lvd(vdd_below_lvd), .bod_en(bod_en),
    .bod_irq_sel(bod_irq_sel), .bod_ie(bod_ie), .lvd_ie(lvd_ie),
    .lvd_wake_en(lvd_wake_en), .bod_flag_clr(bod_flag_clr),
    .lvd_flag_clr(lvd_flag_clr), .ldo_off(ldo_off), .ldo_lcm(ldo_lcm),
    .dmos_on(dmos_on), .sys_rst(sys_rst), .bod_irq(bod_irq), .lvd_irq(lvd_irq),
    .lvd_wake(lvd_wake), .pwr_state(pwr_state)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic enter(input logic [1:0] m);
    mode_req = m; mode_enter = 1'b1;
    tick(1);
    mode_enter = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "state in reset", pwr_state, 0);
    chk("R1", "sys_rst in reset", sys_rst, 1);
    tick(1); rst_n = 1'b1; tick(1);
    chk("R1", "state", pwr_state, 0);
    chk("R1", "ldo_off|lcm|dmos", {ldo_off, ldo_lcm, dmos_on}, 0);
    chk("R1", "irqs", {bod_irq, lvd_irq}, 0);
    chk("R1", "sys_rst", sys_rst, 1);
    tick(16);
    chk("R9", "sys_rst held after power-on", sys_rst, 1);
    tick(1);
    chk("R9", "sys_rst released", sys_rst, 0);
  endtask

  task automatic t_sleep_ds1;
    enter(2'd0);
    chk("R2", "mode_req 0 ignored", pwr_state, 0);
    enter(2'd1);
    chk("R2", "sleep entered", pwr_state, 1);
    chk("R3", "sleep lcm/off", {ldo_lcm, ldo_off}, 0);
    wake_src = 3'b001;
    tick(2);
    chk("R8", "wake not yet seen", pwr_state, 1);
    tick(1);
    chk("R6", "sleep woken", pwr_state, 0);
    wake_src = 3'b000; tick(3);
    enter(2'd2);
    chk("R2", "ds1 entered", pwr_state, 2);
    chk("R3", "ds1 lcm=1 off=0", {ldo_lcm, ldo_off}, 2);
    enter(2'd3);
    chk("R2", "enter ignored outside run", pwr_state, 2);
    ext_rst_n = 1'b0;
    tick(3);
    chk("R6", "nRST fall wakes ds1", pwr_state, 0);
    chk("R3", "run lcm=0", ldo_lcm, 0);
    ext_rst_n = 1'b1; tick(3);
  endtask

  task automatic t_ds2;
    enter(2'd3);
    chk("R4", "ds2 state", pwr_state, 3);
    chk("R4", "ds2 off and dmos", {ldo_off, dmos_on}, 3);
    vdd_above_por = 1'b0; tick(3);
    chk("R9", "sys_rst on por loss", sys_rst, 1);
    wake_src = 3'b010; tick(4);
    chk("R5", "wake ignored below por", pwr_state, 3);
    vdd_above_por = 1'b1;
    tick(3);
    chk("R7", "settle state", pwr_state, 4);
    chk("R7", "settle both on", {ldo_off, dmos_on}, 1);
    tick(3);
    chk("R7", "dmos kept through settle", dmos_on, 1);
    tick(1);
    chk("R7", "run after 4 settle cycles", pwr_state, 0);
    chk("R7", "dmos released", dmos_on, 0);
    wake_src = 3'b000; tick(20);
  endtask

  task automatic t_ds2_bod;
    bod_en = 1'b1; bod_irq_sel = 1'b1; tick(1);
    enter(2'd3);
    chk("R5", "ds2 entered with bod_en", pwr_state, 3);
    tick(1);
    chk("R5", "bod_en above threshold wakes ds2", pwr_state, 4);
    tick(4);
    chk("R7", "back to run", pwr_state, 0);
    bod_en = 1'b0; bod_irq_sel = 1'b0; tick(1);
  endtask

  task automatic t_lvd;
    enter(2'd2);
    lvd_wake_en = 1'b1; vdd_below_lvd = 1'b1;
    tick(2);
    chk("R11", "lvd_wake raised", lvd_wake, 1);
    tick(1);
    chk("R6", "lvd wake leaves ds1", pwr_state, 0);
    chk("R11", "lvd_irq masked", lvd_irq, 0);
    lvd_ie = 1'b1; #1;
    chk("R11", "lvd_irq when enabled", lvd_irq, 1);
    vdd_below_lvd = 1'b0; tick(3);
    chk("R11", "lvd flag sticky", lvd_irq, 1);
    chk("R11", "lvd_wake follows level", lvd_wake, 0);
    lvd_flag_clr = 1'b1; tick(1); lvd_flag_clr = 1'b0;
    chk("R12", "lvd flag cleared", lvd_irq, 0);
    lvd_wake_en = 1'b0; lvd_ie = 1'b0;
  endtask

  task automatic t_bod;
    chk("R9", "no reset before brown-out", sys_rst, 0);
    bod_en = 1'b1; bod_irq_sel = 1'b0; bod_ie = 1'b1; vdd_at_bod = 1'b1;
    tick(2);
    chk("R9", "brown-out reset", sys_rst, 1);
    chk("R10", "no irq in reset mode", bod_irq, 0);
    vdd_at_bod = 1'b0;
    tick(17);
    chk("R9", "brown-out reset stretched", sys_rst, 1);
    tick(1);
    chk("R9", "brown-out reset ends", sys_rst, 0);
    bod_irq_sel = 1'b1; vdd_at_bod = 1'b1;
    tick(2);
    chk("R10", "interrupt mode no reset", sys_rst, 0);
    chk("R10", "flag not yet set", bod_irq, 0);
    tick(1);
    chk("R10", "bod_irq set", bod_irq, 1);
    bod_flag_clr = 1'b1; tick(1); bod_flag_clr = 1'b0;
    chk("R12", "set wins over clear", bod_irq, 1);
    vdd_at_bod = 1'b0; tick(3);
    chk("R10", "bod flag sticky", bod_irq, 1);
    bod_flag_clr = 1'b1; tick(1); bod_flag_clr = 1'b0;
    chk("R12", "bod flag cleared", bod_irq, 0);
    chk("R10", "still no reset", sys_rst, 0);
    bod_en = 1'b0;
  endtask

  initial begin
    tick(3);
    t_reset();
    t_sleep_ds1();
    t_ds2();
    t_ds2_bod();
    t_lvd();
    t_bod();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule